// File: doc/BRIEF.md
# Double-Buffered Vector Block Cache

This block keeps two on-chip copies of a slice of the dense operand vector for a sparse matrix-vector engine. One half is live: the multiply pipeline presents a column index within the current block and gets the matching 64-bit element back one clock later. The other half is the shadow. An incoming burst stream fills it with the next block, one element per accepted beat, and the write index starts at zero and counts up. The order in which blocks are needed is fixed ahead of time, so the shadow can always be filled early.

When the engine moves to the next matrix block, it pulses `advance`. If the shadow half already holds a complete block, the two halves swap roles. The freshly vacated half is marked empty, and `fetch_req` pulses for one cycle so that the upstream fetcher sends the following block. If the shadow half is not yet complete, the request is held and `stall` stays high until the fill finishes; the swap then happens by itself. Beats that arrive while the shadow half is already full are dropped and set a sticky `overflow` flag.

Top module: `vec_block_cache`

## Requirements
- R1: While `rst_n` is low and at the first cycle after release: `live_bank` is 0, `fill_done`, `stall`, `fetch_req` and `overflow` are 0, and `rd_data` is 0.
- R2: The k-th beat accepted since the last swap (k counted from 0) is stored at index k of the shadow half. After the next swap, reading index k returns that beat's data.
- R3: `rd_data` in the cycle after a read address is presented equals the element at that index in the half that was live when the address was sampled.
- R4: `fill_done` is 0 until `BLK_DEPTH` beats have been accepted into the shadow half, and it is 1 from the cycle after the last of them until a swap.
- R5: An `advance` sampled while `fill_done` is 1 toggles `live_bank` and clears `fill_done` at that edge. `fetch_req` is 1 in the following cycle only.
- R6: An `advance` sampled while `fill_done` is 0 raises `stall` from the next cycle. `stall` stays 1 until the first edge at which `fill_done` is 1; that edge performs the swap, as in R5, and lowers `stall`.
- R7: A beat with `fill_valid` high while `fill_done` is 1 does not change any stored element. It sets `overflow`, which stays 1 until reset.
- R8: Filling the shadow half never changes the data read from the live half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Incoming stream beat is valid |
| fill_data | input | ELEM_W | Vector element carried by the beat |
| rd_addr | input | $clog2(BLK_DEPTH) | Column index within the live block |
| rd_data | output | ELEM_W | Element read, one cycle after `rd_addr` |
| advance | input | 1 | Request to move to the next vector block |
| fill_done | output | 1 | Shadow half holds a complete block |
| stall | output | 1 | An advance is waiting for the fill to finish |
| fetch_req | output | 1 | One-cycle pulse asking for the next block |
| overflow | output | 1 | Sticky: a beat arrived while the shadow half was full |
| live_bank | output | 1 | Which physical half is currently live |

## Verification
The properties make no assumption about `advance`. It may be held high or repeated while a stall is pending, and the controller still swaps exactly once for each completed fill. The assertions take for granted that the fill stream is the only writer and that a swap empties the shadow half. Their claims are therefore limited to these: the fill count never passes the block depth, no swap happens from an incomplete half, and the request pulse lands on an empty shadow. The stimulus keeps `fill_valid` low except while a block is streaming in. The one exception is a single deliberate beat into a full half, which exercises the overflow path; its data is distinct from every legal element, so any corruption would show up in the later read-back.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

   typedef enum logic {
      BANK_LO = 1'b0,
      BANK_HI = 1'b1
   } bank_e;

   function automatic bank_e other_bank(input bank_e b);
      return (b == BANK_LO) ? BANK_HI : BANK_LO;
   endfunction

endpackage

// File: rtl/vbc_fill_ctrl.sv
module vbc_fill_ctrl #(
   parameter int BLK_DEPTH = 128,
   localparam int IDX_W = $clog2(BLK_DEPTH),
   localparam int CNT_W = $clog2(BLK_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic             swap,
   output logic             wr_accept,
   output logic [IDX_W-1:0] wr_idx,
   output logic             full,
   output logic             overflow
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BLK_DEPTH);

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;

   assign full      = (cnt_q == CNT_FULL);
   assign wr_accept = wr_valid && !full;
   assign wr_idx    = cnt_q[IDX_W-1:0];
   assign overflow  = ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (swap)
            cnt_q <= '0;
         else if (wr_accept)
            cnt_q <= cnt_q + 1'b1;
         if (wr_valid && full)
            ovf_q <= 1'b1;
      end
   end

   assert_cnt_bound_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

   assert_overflow_sticky_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   assert_swap_from_full_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      swap |-> full);

endmodule

// File: rtl/vbc_swap_ctrl.sv
module vbc_swap_ctrl
   import vbc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  advance,
   input  logic  full,
   output logic  swap,
   output bank_e live,
   output logic  stall,
   output logic  fetch_req
);

   logic  pend_q;
   logic  req_q;
   bank_e live_q;
   logic  want;

   assign want      = advance || pend_q;
   assign swap      = want && full;
   assign live      = live_q;
   assign stall     = pend_q;
   assign fetch_req = req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         req_q  <= 1'b0;
         live_q <= BANK_LO;
      end else begin
         pend_q <= want && !full;
         req_q  <= swap;
         if (swap)
            live_q <= other_bank(live_q);
      end
   end

   assert_req_single_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q);

   assert_stall_release_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> req_q);

   assert_live_moves_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> (live_q != $past(live_q)));

endmodule

// File: rtl/vbc_sdp_ram.sv
module vbc_sdp_ram #(
   parameter int ELEM_W = 64,
   parameter int BLK_DEPTH = 128,
   parameter bit SPLIT_BANKS = 1'b1,
   localparam int IDX_W = $clog2(BLK_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              wbank,
   input  logic [IDX_W-1:0]  widx,
   input  logic [ELEM_W-1:0] wdata,
   input  logic              rbank,
   input  logic [IDX_W-1:0]  ridx,
   output logic [ELEM_W-1:0] rdata
);

   logic [ELEM_W-1:0] rd_q;
   logic [ELEM_W-1:0] rd_word;

   assign rdata = rd_q;

   generate
      if (SPLIT_BANKS) begin : g_split
         logic [ELEM_W-1:0] lo_mem [BLK_DEPTH];
         logic [ELEM_W-1:0] hi_mem [BLK_DEPTH];

         always_ff @(posedge clk) begin
            if (we && !wbank) lo_mem[widx] <= wdata;
            if (we &&  wbank) hi_mem[widx] <= wdata;
         end

         assign rd_word = rbank ? hi_mem[ridx] : lo_mem[ridx];
      end else begin : g_flat
         logic [ELEM_W-1:0] mem [2*BLK_DEPTH];

         always_ff @(posedge clk) begin
            if (we) mem[{wbank, widx}] <= wdata;
         end

         assign rd_word = mem[{rbank, ridx}];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_q <= '0;
      else
         rd_q <= rd_word;
   end

endmodule

// File: rtl/vec_block_cache.sv
module vec_block_cache
   import vbc_pkg::*;
#(
   parameter int ELEM_W = 64,
   parameter int BLK_DEPTH = 128,
   parameter bit SPLIT_BANKS = 1'b1,
   localparam int IDX_W = $clog2(BLK_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_valid,
   input  logic [ELEM_W-1:0] fill_data,
   input  logic [IDX_W-1:0]  rd_addr,
   output logic [ELEM_W-1:0] rd_data,
   input  logic              advance,
   output logic              fill_done,
   output logic              stall,
   output logic              fetch_req,
   output logic              overflow,
   output logic              live_bank
);

   generate
      if (BLK_DEPTH < 2 || (BLK_DEPTH & (BLK_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("vec_block_cache: BLK_DEPTH must be a power of two, at least 2");
      end
      if (ELEM_W < 1) begin : g_bad_width
         $error("vec_block_cache: ELEM_W must be positive");
      end
   endgenerate

   logic             swap;
   logic             wr_accept;
   logic [IDX_W-1:0] wr_idx;
   logic             full;
   bank_e            live;
   bank_e            shadow;

   assign shadow    = other_bank(live);
   assign fill_done = full;
   assign live_bank = live;

   vbc_fill_ctrl #(.BLK_DEPTH(BLK_DEPTH)) fill_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (fill_valid),
      .swap      (swap),
      .wr_accept (wr_accept),
      .wr_idx    (wr_idx),
      .full      (full),
      .overflow  (overflow)
   );

   vbc_swap_ctrl swap_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .full      (full),
      .swap      (swap),
      .live      (live),
      .stall     (stall),
      .fetch_req (fetch_req)
   );

   vbc_sdp_ram #(
      .ELEM_W      (ELEM_W),
      .BLK_DEPTH   (BLK_DEPTH),
      .SPLIT_BANKS (SPLIT_BANKS)
   ) ram_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_accept),
      .wbank (shadow),
      .widx  (wr_idx),
      .wdata (fill_data),
      .rbank (live),
      .ridx  (rd_addr),
      .rdata (rd_data)
   );

   assert_req_on_empty_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> !full);

   assert_stall_not_full_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (stall && full) |=> !stall);

   assert_no_write_when_full_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !wr_accept);

endmodule

// File: tb/vec_block_cache_tb_top.sv
module vec_block_cache_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 64;
   localparam int D  = 128;
   localparam int IW = $clog2(D);
   localparam logic [W-1:0] JUNK = 64'hDEAD_BEEF_0000_0000;

   logic          clk;
   logic          rst_n;
   logic          fill_valid;
   logic [W-1:0]  fill_data;
   logic [IW-1:0] rd_addr;
   logic [W-1:0]  rd_data;
   logic          advance;
   logic          fill_done;
   logic          stall;
   logic          fetch_req;
   logic          overflow;
   logic          live_bank;

   vec_block_cache #(.ELEM_W(W), .BLK_DEPTH(D)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_valid (fill_valid),
      .fill_data  (fill_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .advance    (advance),
      .fill_done  (fill_done),
      .stall      (stall),
      .fetch_req  (fetch_req),
      .overflow   (overflow),
      .live_bank  (live_bank)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   function automatic logic [W-1:0] elem(input int b, input int i);
      return ((64'(b) + 64'd1) << 40) ^ ((64'(i) * 64'h0000_0101_0003) + 64'd7);
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; fill_valid = 1'b0; fill_data = '0; rd_addr = '0; advance = 1'b0;
      repeat (3) tick();
      // R1 reset state
      check("R1 live_bank", 64'(live_bank), 64'd0);
      check("R1 fill_done", 64'(fill_done), 64'd0);
      check("R1 stall", 64'(stall), 64'd0);
      check("R1 fetch_req", 64'(fetch_req), 64'd0);
      check("R1 overflow", 64'(overflow), 64'd0);
      check("R1 rd_data", rd_data, 64'd0);
      rst_n = 1'b1;
      tick();
      check("R1 fill_done after release", 64'(fill_done), 64'd0);

      // R4: fill block 0 into the shadow half
      for (int i = 0; i < D; i++) begin
         fill_valid = 1'b1; fill_data = elem(0, i);
         tick();
         if (i == D - 2) check("R4 not done before last beat", 64'(fill_done), 64'd0);
      end
      fill_valid = 1'b0;
      check("R4 done after last beat", 64'(fill_done), 64'd1);
      check("R4 live unchanged", 64'(live_bank), 64'd0);

      // R5: swap with a complete shadow
      advance = 1'b1; tick(); advance = 1'b0;
      check("R5 live toggled", 64'(live_bank), 64'd1);
      check("R5 fetch_req pulse", 64'(fetch_req), 64'd1);
      check("R5 fill_done cleared", 64'(fill_done), 64'd0);
      check("R5 no stall", 64'(stall), 64'd0);
      tick();
      check("R5 fetch_req one cycle", 64'(fetch_req), 64'd0);

      // R3, R8: strided reads of block 0 while block 1 streams in
      for (int i = 0; i < D; i++) begin
         int a;
         a = (i * 37) % D;
         rd_addr = IW'(a);
         fill_valid = 1'b1; fill_data = elem(1, i);
         tick();
         check("R3/R8 live read during fill", rd_data, elem(0, a));
      end
      check("R4 block 1 complete", 64'(fill_done), 64'd1);

      // R7: beat into a full shadow half
      fill_data = JUNK;
      tick();
      fill_valid = 1'b0;
      check("R7 overflow set", 64'(overflow), 64'd1);
      tick();
      check("R7 overflow sticky", 64'(overflow), 64'd1);

      advance = 1'b1; tick(); advance = 1'b0;
      check("R5 second swap live", 64'(live_bank), 64'd0);
      check("R5 second swap request", 64'(fetch_req), 64'd1);

      // R2, R7: descending read-back of block 1, dropped beat left no trace
      for (int i = 0; i < D; i++) begin
         rd_addr = IW'(D - 1 - i);
         tick();
         check("R2/R7 block 1 read-back", rd_data, elem(1, D - 1 - i));
      end

      // R6: advance with an empty shadow half
      advance = 1'b1; tick(); advance = 1'b0;
      check("R6 stall raised", 64'(stall), 64'd1);
      check("R6 no swap yet", 64'(live_bank), 64'd0);
      for (int i = 0; i < D; i++) begin
         fill_valid = 1'b1; fill_data = elem(2, i);
         if (i == 3) advance = 1'b1;
         tick();
         advance = 1'b0;
         check("R6 stall held during fill", 64'(stall), 64'd1);
      end
      fill_valid = 1'b0;
      check("R6 fill_done while stalled", 64'(fill_done), 64'd1);
      tick();
      check("R6 stall released", 64'(stall), 64'd0);
      check("R6 swap on completion", 64'(live_bank), 64'd1);
      check("R6 request on release", 64'(fetch_req), 64'd1);
      check("R6 shadow emptied", 64'(fill_done), 64'd0);
      tick();
      check("R6 single swap", 64'(live_bank), 64'd1);

      for (int i = 0; i < D; i++) begin
         int a;
         a = (i * 5 + 3) % D;
         rd_addr = IW'(a);
         tick();
         check("R2 block 2 read-back", rd_data, elem(2, a));
      end
      check("R7 overflow still set", 64'(overflow), 64'd1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule